// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Bus Master

This block is the bus-cycle engine of a 32-bit processor whose external bus carries the address and the data on the same 32 lines. An internal requester presents a byte address, a beat count (one to four) and a bus width (8, 16 or 32 bits), together with up to four words of write data. The block then runs one address cycle followed by the data cycles. It paces each data beat on an active-low ready input. On reads it returns every captured beat with its index and a last-beat flag.

The beat count is encoded into the two low AD lines during the address cycle. A four-bit partial address starts at the access's aligned offset within its 16-byte block and advances by the bus width on every ready beat. Its upper two bits go out on dedicated pins, and its lower bits go out on the byte-enable pins for narrow buses. A simple hold handshake floats the bus. A halt input makes the AD lines show a defined record of the last transfer.

Top module: `adbus_master`

## Requirements
- R1: While reset is asserted, ale is 0, ale_n and ads_n are 1, ad_out and a_part are all zero, ad_oe and ctl_oe are 1, and req_ready is 1 once reset is released with halt and hold_req low.
- R2: In the cycle after a request is accepted, ads_n is 0 and ale is 1 for exactly one cycle. During that cycle ad_out carries {address[31:2], beats-1}, where beats-1 is 00 for one transfer and up to 11 for four. In the following cycle ale is 0 and ads_n is 1.
- R3: ale_n is the inverse of ale in every cycle.
- R4: In a write data cycle ad_oe is 1. ad_out carries the beat's data word (word k of req_wdata, bits 32k+31:32k) on the low lanes for the bus width: all four lanes for width code 2 (32-bit), lanes 1..0 for code 1 (16-bit), lane 0 for code 0 (8-bit). Every unused lane carries FILL_BYTE. In a read data cycle ad_oe is 0.
- R5: The partial address starts at address[3:0] with its low bits cleared to the width's alignment. It advances by 4, 2 or 1 on each cycle that rdy_n is sampled low, and holds while rdy_n is high. a_part shows its bits [3:2] from the address cycle on. be_n is 0000 for 32-bit, {00, A1, 0} for 16-bit and {00, A1, A0} for 8-bit.
- R6: When rdy_n is sampled low in a read data cycle, the next cycle shows rd_valid=1 with rd_data equal to ad_in at that edge, rd_beat equal to the beat index and rd_last set on the final beat. rd_valid stays 0 for writes.
- R7: After beats-1 plus one ready beats the block returns to idle, and req_ready is 1 in the next cycle.
- R8: A request with width code 3, or whose last beat would fall beyond offset 15 of its 16-byte block, raises req_err for one cycle and starts no address cycle.
- R9: hold_req is granted only from idle, with hold_ack=1 from the next cycle on, and during hold ad_oe and ctl_oe are 0. A hold_req raised during a burst leaves hold_ack 0 until the burst ends.
- R10: In halt after a write, ad_out is {last write data word[31:2], beats-1 of that transfer}.
- R11: In halt after a read, ad_out is {address[31:4], partial address bits [3:2] of the last beat, beats-1 of that transfer}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_beats | input | 2 | Number of transfers minus one |
| req_width | input | 2 | Bus width: 0 = 8, 1 = 16, 2 = 32 bit |
| req_wdata | input | 128 | Write words, beat k in bits 32k+31:32k |
| req_ready | output | 1 | Request can be taken this cycle |
| req_err | output | 1 | Request rejected |
| rdy_n | input | 1 | Active-low beat ready |
| ad_in | input | 32 | AD lines as received |
| ad_out | output | 32 | AD lines as driven |
| ad_oe | output | 1 | AD output enable |
| ctl_oe | output | 1 | Enable for ale, ale_n, ads_n, a_part, be_n |
| ale | output | 1 | Address latch enable |
| ale_n | output | 1 | Inverse of ale |
| ads_n | output | 1 | Active-low address strobe |
| a_part | output | 2 | Partial address bits [3:2] |
| be_n | output | 4 | Byte enables / low address bits |
| rd_valid | output | 1 | Read beat captured |
| rd_data | output | 32 | Captured read data |
| rd_beat | output | 2 | Index of captured beat |
| rd_last | output | 1 | Captured beat is the last |
| hold_req | input | 1 | Bus hold request |
| hold_ack | output | 1 | Bus hold granted |
| halt | input | 1 | Halt mode |

## Verification
The bench builds the block with FILL_BYTE set to A5 rather than the default zero. This makes the fill of unused write lanes distinguishable from real data bytes and from an undriven zero. With this value, a lane placed wrongly on a 8- or 16-bit write shows up directly on ad_out. The same holds in the halt record after a narrow write, whose upper bits come from fill lanes.

// File: rtl/adbus_master.sv
module adbus_master #(
  parameter logic [7:0] FILL_BYTE = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [31:0]  req_addr,
  input  logic [1:0]   req_beats,
  input  logic [1:0]   req_width,
  input  logic [127:0] req_wdata,
  output logic         req_ready,
  output logic         req_err,
  input  logic         rdy_n,
  input  logic [31:0]  ad_in,
  output logic [31:0]  ad_out,
  output logic         ad_oe,
  output logic         ctl_oe,
  output logic         ale,
  output logic         ale_n,
  output logic         ads_n,
  output logic [1:0]   a_part,
  output logic [3:0]   be_n,
  output logic         rd_valid,
  output logic [31:0]  rd_data,
  output logic [1:0]   rd_beat,
  output logic         rd_last,
  input  logic         hold_req,
  output logic         hold_ack,
  input  logic         halt
);

  typedef enum logic [2:0] {S_IDLE, S_TA, S_TD, S_HOLD, S_HALT} st_t;
  st_t st;

  logic         wr_r;
  logic [29:0]  wa_r;
  logic [1:0]   sz_r, wd_r, cnt;
  logic [3:0]   pa;
  logic [127:0] wdat_r;

  logic         last_wr;
  logic [29:0]  last_w;
  logic [27:0]  last_hi;
  logic [1:0]   last_pa, last_sz;

  logic [3:0]  step_in, pa_in, step_r;
  logic [4:0]  span, end_in;
  logic        bad_in;
  logic [31:0] bw, lane_word, halt_word;

  assign step_in = 4'd1 << req_width;
  assign pa_in   = req_addr[3:0] & ~(step_in - 4'd1);
  assign span    = 5'(req_beats) * 5'(step_in);
  assign end_in  = {1'b0, pa_in} + span;
  assign bad_in  = (req_width == 2'd3) || (end_in > 5'd15);
  assign step_r  = 4'd1 << wd_r;

  assign bw = wdat_r[{cnt, 5'b0} +: 32];
  always_comb
    case (wd_r)
      2'd0:    lane_word = {{3{FILL_BYTE}}, bw[7:0]};
      2'd1:    lane_word = {{2{FILL_BYTE}}, bw[15:0]};
      default: lane_word = bw;
    endcase

  assign halt_word = last_wr ? {last_w, last_sz} : {last_hi, last_pa, last_sz};

  assign req_ready = (st == S_IDLE) && !halt && !hold_req;
  assign ale       = (st == S_TA);
  assign ale_n     = ~ale;
  assign ads_n     = (st != S_TA);
  assign hold_ack  = (st == S_HOLD);
  assign ctl_oe    = (st != S_HOLD);
  assign ad_oe     = !((st == S_HOLD) || (st == S_TD && !wr_r));
  assign a_part    = pa[3:2];

  always_comb
    case (st)
      S_TA:    ad_out = {wa_r, sz_r};
      S_TD:    ad_out = wr_r ? lane_word : 32'h0;
      S_HALT:  ad_out = halt_word;
      default: ad_out = 32'h0;
    endcase

  always_comb
    case (wd_r)
      2'd0:    be_n = {2'b00, pa[1:0]};
      2'd1:    be_n = {2'b00, pa[1], 1'b0};
      default: be_n = 4'b0000;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      wr_r <= 1'b0; wa_r <= '0; sz_r <= '0; wd_r <= '0; cnt <= '0; pa <= '0;
      wdat_r <= '0;
      last_wr <= 1'b0; last_w <= '0; last_hi <= '0; last_pa <= '0; last_sz <= '0;
      req_err <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0; rd_beat <= '0; rd_last <= 1'b0;
    end else begin
      req_err  <= req_valid && req_ready && bad_in;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (halt) st <= S_HALT;
          else if (hold_req) st <= S_HOLD;
          else if (req_valid && !bad_in) begin
            wr_r   <= req_write;
            wa_r   <= req_addr[31:2];
            sz_r   <= req_beats;
            wd_r   <= req_width;
            pa     <= pa_in;
            cnt    <= 2'd0;
            wdat_r <= req_wdata;
            st     <= S_TA;
          end
        S_TA: st <= S_TD;
        S_TD:
          if (!rdy_n) begin
            last_wr <= wr_r;
            last_sz <= sz_r;
            last_hi <= wa_r[29:2];
            last_pa <= pa[3:2];
            if (wr_r) last_w <= lane_word[31:2];
            else begin
              rd_valid <= 1'b1;
              rd_data  <= ad_in;
              rd_beat  <= cnt;
              rd_last  <= (cnt == sz_r);
            end
            if (cnt == sz_r) st <= S_IDLE;
            else begin
              cnt <= cnt + 2'd1;
              pa  <= pa + step_r;
            end
          end
        S_HOLD: if (!hold_req) st <= S_IDLE;
        S_HALT: if (!halt) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

endmodule

// File: rtl/adbus_master_chk.sv
module adbus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_err,
  input logic rdy_n,
  input logic ad_oe,
  input logic ctl_oe,
  input logic ale,
  input logic ads_n,
  input logic rd_valid,
  input logic hold_req,
  input logic hold_ack
);

  AST_TA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !ads_n |=> ads_n); // R2
  AST_ALE_WITH_ADS: assert property (@(posedge clk) disable iff (!rst_n) ale |-> !ads_n); // R2
  AST_HOLD_FLOAT:   assert property (@(posedge clk) disable iff (!rst_n) hold_ack |-> (!ad_oe && !ctl_oe)); // R9
  AST_HOLD_ON_REQ:  assert property (@(posedge clk) disable iff (!rst_n) $rose(hold_ack) |-> $past(hold_req)); // R9
  AST_ERR_NO_TA:    assert property (@(posedge clk) disable iff (!rst_n) req_err |-> ads_n); // R8
  AST_RD_ON_READY:  assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(!rdy_n)); // R6

endmodule

bind adbus_master adbus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_err(req_err), .rdy_n(rdy_n), .ad_oe(ad_oe),
  .ctl_oe(ctl_oe), .ale(ale), .ads_n(ads_n), .rd_valid(rd_valid),
  .hold_req(hold_req), .hold_ack(hold_ack)
);

// File: tb/tb_adbus_master.sv
module tb_adbus_master;
  localparam logic [7:0] FILL = 8'hA5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_beats = 0, req_width = 0;
  logic [127:0] req_wdata = 0;
  logic req_ready, req_err;
  logic rdy_n = 1;
  logic [31:0] ad_in = 0, ad_out, rd_data;
  logic ad_oe, ctl_oe, ale, ale_n, ads_n, rd_valid, rd_last, hold_ack;
  logic [1:0] a_part, rd_beat;
  logic [3:0] be_n;
  logic hold_req = 0, halt = 0;

  int nchk = 0, nbad = 0;
  logic        g_wr;
  logic [31:0] g_addr, g_word;
  logic [1:0]  g_sz;
  logic [3:0]  g_pa;

  adbus_master #(.FILL_BYTE(FILL)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  function automatic logic [3:0] f_step(input logic [1:0] w);
    return 4'd1 << w;
  endfunction
  function automatic logic [3:0] f_pa0(input logic [31:0] a, input logic [1:0] w);
    return a[3:0] & ~(f_step(w) - 4'd1);
  endfunction
  function automatic bit f_bad(input logic [31:0] a, input logic [1:0] b, input logic [1:0] w);
    return (w == 2'd3) || (int'(f_pa0(a, w)) + int'(b) * int'(f_step(w)) > 15);
  endfunction
  function automatic logic [3:0] f_be(input logic [1:0] w, input logic [3:0] p);
    case (w)
      2'd0: return {2'b00, p[1:0]};
      2'd1: return {2'b00, p[1], 1'b0};
      default: return 4'b0000;
    endcase
  endfunction
  function automatic logic [31:0] f_lane(input logic [1:0] w, input logic [31:0] d);
    case (w)
      2'd0: return {FILL, FILL, FILL, d[7:0]};
      2'd1: return {FILL, FILL, d[15:0]};
      default: return d;
    endcase
  endfunction

  task automatic do_txn(input bit wr, input logic [31:0] addr, input logic [1:0] beats,
                        input logic [1:0] w, input logic [127:0] wd, input int maxstall,
                        input bit hold_mid);
    logic [3:0] p;
    req_valid = 1; req_write = wr; req_addr = addr; req_beats = beats;
    req_width = w; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    if (f_bad(addr, beats, w)) begin
      chk("R8 err pulse", req_err, 1);
      chk("R8 no strobe", ads_n, 1);
      @(posedge clk); @(negedge clk);
      chk("R8 err one cycle", req_err, 0);
      chk("R8 still no strobe", ads_n, 0 + 1);
      return;
    end
    p = f_pa0(addr, w);
    chk("R2 ads low", ads_n, 0);
    chk("R2 ale high", ale, 1);
    chk("R3 ale_n", ale_n, 0);
    chk("R2 addr+size", ad_out, {addr[31:2], beats});
    chk("R5 a_part in Ta", a_part, p[3:2]);
    if (hold_mid) hold_req = 1;
    @(posedge clk); @(negedge clk);
    chk("R2 ale low in Td", ale, 0);
    chk("R2 ads high in Td", ads_n, 1);
    chk("R3 ale_n in Td", ale_n, 1);
    for (int b = 0; b <= int'(beats); b++) begin
      int st;
      logic [31:0] rv, lw;
      st = int'($urandom % (maxstall + 1));
      lw = f_lane(w, wd[b*32 +: 32]);
      for (int s = 0; s <= st; s++) begin
        rdy_n = (s == st) ? 1'b0 : 1'b1;
        rv = $urandom; ad_in = rv;
        chk("R5 a_part", a_part, p[3:2]);
        chk("R5 be_n", be_n, f_be(w, p));
        chk("R4 ad_oe", ad_oe, wr);
        if (wr) chk("R4 lanes", ad_out, lw);
        if (hold_mid) chk("R9 no hold mid-burst", hold_ack, 0);
        @(posedge clk); @(negedge clk);
      end
      rdy_n = 1;
      if (wr) chk("R6 no rd_valid on write", rd_valid, 0);
      else begin
        chk("R6 rd_valid", rd_valid, 1);
        chk("R6 rd_data", rd_data, rv);
        chk("R6 rd_beat", rd_beat, b[1:0]);
        chk("R6 rd_last", rd_last, (b == int'(beats)));
      end
      g_wr = wr; g_addr = addr; g_sz = beats; g_pa = p; g_word = lw;
      if (b != int'(beats)) p = p + f_step(w);
    end
    if (hold_mid) begin
      chk("R9 idle but hold pending", req_ready, 0);
      chk("R9 hold not yet", hold_ack, 0);
    end else begin
      chk("R7 back to idle", req_ready, 1);
    end
  endtask

  task automatic halt_check(input string tag, input logic [31:0] exp);
    halt = 1;
    @(posedge clk); @(negedge clk);
    chk(tag, ad_out, exp);
    chk({tag, " oe"}, ad_oe, 1);
    chk({tag, " not ready"}, req_ready, 0);
    halt = 0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nbad++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 ale", ale, 0);
    chk("R1 ale_n", ale_n, 1);
    chk("R1 ads_n", ads_n, 1);
    chk("R1 ad_out", ad_out, 0);
    chk("R1 a_part", a_part, 0);
    chk("R1 oe", {ad_oe, ctl_oe}, 2'b11);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);

    do_txn(1, 32'h1000_0000, 2'd3, 2'd2, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'hDEAD_BEEF}, 2, 0);
    halt_check("R10 halt after write", {32'h4444_4444 >> 2, 2'd3});
    do_txn(0, 32'h2000_0042, 2'd2, 2'd1, 128'h0, 1, 0);
    halt_check("R11 halt after read", {32'h2000_0042 >> 4, 2'b01, 2'd2});
    do_txn(1, 32'h3000_000C, 2'd3, 2'd0, {32'h44, 32'h33, 32'h22, 32'h11}, 0, 0);
    halt_check("R10 halt after narrow write", {FILL, FILL, FILL, 6'h11, 2'd3});
    do_txn(1, 32'h4000_000C, 2'd1, 2'd2, 128'h1, 0, 0);
    do_txn(0, 32'h4000_0000, 2'd0, 2'd3, 128'h0, 0, 0);
    do_txn(0, 32'h4000_000F, 2'd1, 2'd0, 128'h0, 0, 0);

    hold_req = 1;
    @(posedge clk); @(negedge clk);
    chk("R9 hold ack", hold_ack, 1);
    chk("R9 float", {ad_oe, ctl_oe}, 2'b00);
    chk("R9 not ready", req_ready, 0);
    hold_req = 0;
    @(posedge clk); @(negedge clk);
    chk("R9 release", {hold_ack, req_ready}, 2'b01);

    do_txn(0, 32'h5000_0004, 2'd2, 2'd2, 128'h0, 1, 1);
    @(posedge clk); @(negedge clk);
    chk("R9 hold after burst", hold_ack, 1);
    chk("R9 float after burst", {ad_oe, ctl_oe}, 2'b00);
    hold_req = 0;
    @(posedge clk); @(negedge clk);

    for (int i = 0; i < 80; i++) begin
      logic [31:0] a;
      logic [1:0] bts, w;
      bit wr;
      a = $urandom; bts = 2'($urandom); w = 2'($urandom % 4); wr = 1'($urandom);
      do_txn(wr, a, bts, w, {$urandom, $urandom, $urandom, $urandom}, 3, 0);
      if (!f_bad(a, bts, w) && (i % 10 == 0)) begin
        if (g_wr) halt_check("R10 random halt", {g_word[31:2], g_sz});
        else      halt_check("R11 random halt", {g_addr[31:4], g_pa[3:2], g_sz});
      end
    end

    summary();
    $finish;
  end
endmodule